// File: doc/BRIEF.md
# Power-Button Input Controller

This block turns one power-button pin into two single-cycle request pulses: a turn-on request and a turn-off/sleep request. A configuration input selects one of two behaviours. In level mode the pin acts as a plain enable. A high level asks for power-on and a low level asks for power-off or sleep. In edge mode the pin is driven by a momentary push button. Pressing the button, which pulls the pin low, asks for power-on. Keeping it pressed for four seconds asks for power-off or sleep.

The raw pin first passes through a two-flop synchronizer. A debouncer then accepts a new level only after the level has stayed stable for a set number of millisecond ticks. All pulse decisions are made on the debounced level. The long-press timer counts the same millisecond tick, so every timing in the block is expressed in ticks. The surrounding power controller supplies the current power state. That state suppresses a redundant turn-on pulse, and it also gates the long-press turn-off pulse. The controller then decides between off and sleep and runs the sequencing that follows.

Top module: `pwrbtn_ctrl`

## Requirements
- R1: After reset both pulse outputs are low. A pin held low through and after reset produces no pulse, because the debounced level starts low and a press is only recognised after the level has been debounced high.
- R2: A synchronized level that differs from the debounced level for fewer than DEBOUNCE_MS consecutive ticks has no effect. A level that persists through DEBOUNCE_MS ticks is taken over on the DEBOUNCE_MS-th tick. Pulses change only in the two cycles after a tick.
- R3: With mode_edge = 0, a debounced rise gives exactly one on_pulse and a debounced fall gives exactly one off_pulse. In this mode is_on has no effect.
- R4: With mode_edge = 1, a debounced fall while is_on = 0 gives exactly one on_pulse. For a press that starts with the pin low after tick t0, the pulse appears after tick t0 + DEBOUNCE_MS.
- R5: With mode_edge = 1, a debounced fall while is_on = 1 gives no on_pulse. It only starts the hold timer.
- R6: With mode_edge = 1, a debounced rise produces no pulse.
- R7: With mode_edge = 1 and is_on = 1, a pin held low for HOLD_MS ticks gives one off_pulse after tick t0 + DEBOUNCE_MS + HOLD_MS. A pin held low for HOLD_MS - 1 ticks gives none. The hold time counts from the debounced fall to the debounced rise.
- R8: A hold longer than HOLD_MS gives only one off_pulse. No further off_pulse comes until the pin has been debounced high again.
- R9: With mode_edge = 1, a hold that reaches HOLD_MS while is_on = 0 gives no off_pulse.
- R10: Each pulse lasts exactly one clock cycle, and on_pulse and off_pulse are never high in the same cycle.
- R11: With mode_edge = 0, a pin held high through reset gives one on_pulse after DEBOUNCE_MS ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_raw | input | 1 | Raw, asynchronous power-button pin |
| mode_edge | input | 1 | 0 = level mode, 1 = push-button (edge) mode |
| ms_tick | input | 1 | One-cycle strobe once per millisecond |
| is_on | input | 1 | Current power state from the power controller (1 = on) |
| on_pulse | output | 1 | One-cycle turn-on request |
| off_pulse | output | 1 | One-cycle turn-off/sleep request |

## Verification
Several properties are checked on every cycle by assertions: the pulses last one cycle and never overlap, every pulse follows a tick, a push-button on_pulse never comes while the block is already on, a long-press off_pulse always comes while it is on, and a single hold never gives a second off_pulse. The exact tick on which each pulse lands can only be shown by the bench scenarios. The same holds for the thresholds one tick short of and exactly at the debounce window and the four-second hold, for the silence of a pin held low at reset, and for level mode ignoring is_on.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

  typedef enum logic [1:0] {
    HOLD_IDLE = 2'd0,
    HOLD_RUN  = 2'd1,
    HOLD_DONE = 2'd2
  } hold_state_t;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

endpackage

// File: rtl/pbc_rst_sync.sv
module pbc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pbc_sync.sv
module pbc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pbc_debounce.sv
module pbc_debounce
  import pbc_pkg::*;
#(
  parameter int unsigned STABLE_TICKS = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic level_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  localparam int unsigned CW = cnt_width(STABLE_TICKS);
  localparam logic [CW-1:0] LAST = CW'(STABLE_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic          rise_q, rise_d;
  logic          fall_q, fall_d;
  logic          differs;
  logic          cnt_en;

  assign differs = (level_i != lvl_q);
  assign cnt_en  = differs && tick_i;

  always_comb begin
    cnt_d  = cnt_q;
    lvl_d  = lvl_q;
    rise_d = 1'b0;
    fall_d = 1'b0;
    if (!differs) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        lvl_d  = level_i;
        rise_d = level_i;
        fall_d = !level_i;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lvl_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lvl_q  <= lvl_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign level_o = lvl_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;

endmodule

// File: rtl/pbc_press_fsm.sv
module pbc_press_fsm
  import pbc_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic mode_edge,
  input  logic is_on,
  input  logic rise_i,
  input  logic fall_i,
  output logic on_o,
  output logic off_o
);

  localparam int unsigned CW = cnt_width(HOLD_TICKS);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  hold_state_t   st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          on_q, on_d;
  logic          off_q, off_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    on_d  = 1'b0;
    off_d = 1'b0;
    if (!mode_edge) begin
      st_d  = HOLD_IDLE;
      cnt_d = '0;
      on_d  = rise_i;
      off_d = fall_i;
    end else begin
      unique case (st_q)
        HOLD_IDLE: begin
          if (fall_i) begin
            on_d  = !is_on;
            st_d  = HOLD_RUN;
            cnt_d = '0;
          end
        end
        HOLD_RUN: begin
          if (rise_i) begin
            st_d  = HOLD_IDLE;
            cnt_d = '0;
          end else if (tick_i) begin
            if (cnt_q == LAST) begin
              off_d = is_on;
              st_d  = HOLD_DONE;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        HOLD_DONE: begin
          if (rise_i) begin
            st_d  = HOLD_IDLE;
            cnt_d = '0;
          end
        end
        default: begin
          st_d  = HOLD_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= HOLD_IDLE;
      cnt_q <= '0;
      on_q  <= 1'b0;
      off_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      on_q  <= on_d;
      off_q <= off_d;
    end
  end

  assign on_o  = on_q;
  assign off_o = off_q;

endmodule

// File: rtl/pwrbtn_ctrl.sv
module pwrbtn_ctrl #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEBOUNCE_MS = 30,
  parameter int unsigned HOLD_MS     = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  input  logic mode_edge,
  input  logic ms_tick,
  input  logic is_on,
  output logic on_pulse,
  output logic off_pulse
);

  logic rst_int_n;
  logic pin_sync;
  logic db_level;
  logic db_rise;
  logic db_fall;

  pbc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pbc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i (pin_raw),
    .sync_o  (pin_sync)
  );

  pbc_debounce #(.STABLE_TICKS(DEBOUNCE_MS)) u_db (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick_i  (ms_tick),
    .level_i (pin_sync),
    .level_o (db_level),
    .rise_o  (db_rise),
    .fall_o  (db_fall)
  );

  pbc_press_fsm #(.HOLD_TICKS(HOLD_MS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick_i    (ms_tick),
    .mode_edge (mode_edge),
    .is_on     (is_on),
    .rise_i    (db_rise),
    .fall_i    (db_fall),
    .on_o      (on_pulse),
    .off_o     (off_pulse)
  );

endmodule

// File: rtl/pbc_chk.sv
module pbc_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_edge,
  input logic ms_tick,
  input logic is_on,
  input logic db_level,
  input logic on_pulse,
  input logic off_pulse
);

  logic held_off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_off_q <= 1'b0;
    end else if (db_level || !mode_edge) begin
      held_off_q <= 1'b0;
    end else if (off_pulse) begin
      held_off_q <= 1'b1;
    end
  end

  // R10
  on_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_pulse |=> !on_pulse);

  // R10
  off_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_pulse |=> !off_pulse);

  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(on_pulse && off_pulse));

  // R2
  after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_pulse || off_pulse) |-> ($past(ms_tick) || $past(ms_tick, 2)));

  // R5
  no_redundant_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_pulse && $past(mode_edge)) |-> !$past(is_on));

  // R9
  off_needs_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (off_pulse && $past(mode_edge)) |-> $past(is_on));

  // R8
  one_off_per_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_off_q && mode_edge && $past(mode_edge)) |-> !off_pulse);

endmodule

bind pwrbtn_ctrl pbc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_edge (mode_edge),
  .ms_tick   (ms_tick),
  .is_on     (is_on),
  .db_level  (db_level),
  .on_pulse  (on_pulse),
  .off_pulse (off_pulse)
);

// File: tb/sim_pwrbtn_ctrl.sv
`timescale 1ns/1ps
module sim_pwrbtn_ctrl;

  localparam int DB   = 30;
  localparam int HOLD = 4000;

  logic clk = 1'b0;
  logic rst_n, pin_raw, mode_edge, ms_tick, is_on;
  logic on_pulse, off_pulse;

  int compared = 0, mismatched = 0;
  int cyc = 0, tick_no = 0;
  int n_on = 0, n_off = 0, last_on = -1, last_off = -1;
  int shape_err = 0;
  logic prev_on = 1'b0, prev_off = 1'b0;

  always #4 clk = ~clk;

  pwrbtn_ctrl #(.DEBOUNCE_MS(DB), .HOLD_MS(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .mode_edge(mode_edge),
    .ms_tick(ms_tick), .is_on(is_on), .on_pulse(on_pulse), .off_pulse(off_pulse)
  );

  always @(posedge clk) begin
    #2;
    if (on_pulse) begin n_on++; last_on = tick_no; end
    if (off_pulse) begin n_off++; last_off = tick_no; end
    if ((on_pulse && prev_on) || (off_pulse && prev_off) || (on_pulse && off_pulse))
      shape_err++;
    prev_on = on_pulse;
    prev_off = off_pulse;
  end

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    ms_tick = (cyc % 4 == 0);
    if (ms_tick) tick_no++;
  endtask

  task automatic align();
    do step(); while (cyc % 4 != 1);
  endtask

  task automatic until_tick(input int target);
    while (!(tick_no >= target && cyc % 4 == 1)) step();
  endtask

  // Expected pulse counts for a low press of d ticks starting from a debounced-high pin
  function automatic int exp_on(input logic m, input logic on_st, input int d);
    if (d < DB) return 0;
    if (!m) return 1;
    return on_st ? 0 : 1;
  endfunction

  function automatic int exp_off(input logic m, input logic on_st, input int d);
    if (d < DB) return 0;
    if (!m) return 1;
    return (on_st && d >= HOLD) ? 1 : 0;
  endfunction

  int t0;

  task automatic press(input string req, input logic m, input logic on_st, input int d);
    int b_on, b_off;
    mode_edge = m;
    is_on = on_st;
    align();
    b_on = n_on;
    b_off = n_off;
    pin_raw = 1'b0;
    t0 = tick_no;
    until_tick(t0 + d);
    pin_raw = 1'b1;
    until_tick(t0 + d + DB + 8);
    check({req, " on count"}, n_on - b_on, exp_on(m, on_st, d));
    check({req, " off count"}, n_off - b_off, exp_off(m, on_st, d));
  endtask

  task automatic do_reset(input logic pin_level, input logic m);
    rst_n = 1'b0;
    pin_raw = pin_level;
    mode_edge = m;
    is_on = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog R1..R11 actual=timeout expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int b0;
    ms_tick = 1'b0;
    void'($urandom(32'h5eed_0042));
    // R1: pin low at reset, edge mode
    do_reset(1'b0, 1'b1);
    step();
    check("R1 on_pulse after reset", int'(on_pulse), 0);
    check("R1 off_pulse after reset", int'(off_pulse), 0);
    until_tick(tick_no + 100);
    check("R1 no pulse while held low", n_on + n_off, 0);

    // R6: first debounced rise in edge mode is silent
    align();
    pin_raw = 1'b1;
    until_tick(tick_no + DB + 8);
    check("R6 rise gives no pulse", n_on + n_off, 0);

    // R2: one tick short of the debounce window
    press("R2 short press", 1'b1, 1'b0, DB - 1);

    // R2/R4: exactly the debounce window, turn-on at t0+DB
    press("R4 press from off", 1'b1, 1'b0, DB);
    check("R4 on tick", last_on, t0 + DB);

    // R5: press while on
    press("R5 press while on", 1'b1, 1'b1, 50);

    // R7: one tick short of hold, then exactly hold
    press("R7 hold minus one", 1'b1, 1'b1, HOLD - 1);
    press("R7 exact hold", 1'b1, 1'b1, HOLD);
    check("R7 off tick", last_off, t0 + DB + HOLD);

    // R8: long hold, a single off pulse
    press("R8 long hold", 1'b1, 1'b1, HOLD + 300);
    check("R8 off tick", last_off, t0 + DB + HOLD);

    // R9: hold reaches limit while off
    press("R9 hold while off", 1'b1, 1'b0, HOLD + 10);

    // R3: level mode, is_on ignored
    press("R3 level press on", 1'b0, 1'b1, 40);
    check("R3 off tick", last_off, t0 + DB);
    check("R3 on tick", last_on, t0 + 40 + DB);
    press("R3 level press off", 1'b0, 1'b0, 45);
    check("R3 on tick is_on=0", last_on, t0 + 45 + DB);
    press("R2 level short", 1'b0, 1'b1, DB - 1);

    // Random presses below the hold limit
    for (int i = 0; i < 24; i++) begin
      logic m, o;
      int d;
      m = 1'($urandom_range(0, 1));
      o = 1'($urandom_range(0, 1));
      d = int'($urandom_range(1, 90));
      press($sformatf("R2/R3/R4/R5 random %0d d=%0d m=%0d", i, d, m), m, o, d);
    end

    // R11: pin high through reset in level mode
    do_reset(1'b1, 1'b0);
    b0 = n_on;
    t0 = tick_no;
    until_tick(tick_no + DB + 8);
    check("R11 one on pulse", n_on - b0, 1);
    check("R11 on within window", int'(last_on >= t0 + DB - 1 && last_on <= t0 + DB + 1), 1);

    check("R10 pulse shape", shape_err, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule